// File: doc/BRIEF.md
# Periodic Interrupt Flag Controller

This block produces the periodic event of a real-time clock and holds the status flag that goes with it. A free-running tick counter, advanced by a 32.768 kHz enable, fires an event every time the selected interval elapses. The event sets a one-bit flag. An active-low request line is driven low for exactly as long as that flag is set.

How the flag is cleared depends on the mode bit. In interrupt mode the flag stays set until the host reads it. A read can be deferred by a short hold-off window when delay protection is on. Writes have no effect in this mode, and further events are ignored while the flag is set. In pulse mode the flag clears itself after half the selected interval, or earlier if the host writes a zero. Reads have no effect in pulse mode. A mask bit stops events and clears all pending state.

All pins are plain control and status signals. The read and write strobes are single-cycle pulses with no handshake and no back-pressure: a strobe acts in the cycle it is high.

Top module: `rtc_periodic_flag`

## Requirements
- R1: After reset, `flag_o` is 0 and `req_n_o` is 1.
- R2: `req_n_o` is 0 in every cycle where `flag_o` is 1, and 1 in every cycle where `flag_o` is 0.
- R3: With `mask` at 0, an event fires on every tick that completes an interval of `4 << period_sel` ticks. The count restarts at the event. `flag_o` rises on the clock after that tick.
- R4: With `mask` at 1, the flag, the hold-off state and the interval counter are cleared on the next clock, and no event fires.
- R5: In interrupt mode (`irq_mode` = 1) with `delay_protect` = 0, the flag stays at 1 until a read strobe. It is 0 on the clock after the read.
- R6: In interrupt mode, a write strobe leaves the flag unchanged, whatever the write data.
- R7: In interrupt mode, an event that arrives while the flag is 1 is ignored. It neither re-sets the flag nor restarts the tick age counted since the first event.
- R8: In interrupt mode with `delay_protect` = 1, a read that arrives before 4 ticks have been counted since the event is deferred. The flag then drops on the clock after the 4th tick. A read at or after the 4th tick clears the flag on the next clock.
- R9: In pulse mode (`irq_mode` = 0), the flag clears itself on the clock after the Nth tick that follows the event, where N = max((4 << period_sel)/2, 1).
- R10: In pulse mode, a write strobe with `flag_wdata` = 0 clears the flag on the next clock. A write with `flag_wdata` = 1 changes nothing.
- R11: In pulse mode, a read strobe does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 32.768 kHz time-base enable |
| period_sel | input | 3 | Interval select, interval = 4 << period_sel ticks |
| irq_mode | input | 1 | 1 = interrupt mode, 0 = pulse mode |
| mask | input | 1 | 1 = events blocked and state cleared |
| delay_protect | input | 1 | 1 = read clear deferred until 4 ticks after the event |
| flag_rd | input | 1 | Host read strobe of the flag |
| flag_wr | input | 1 | Host write strobe of the flag |
| flag_wdata | input | 1 | Data bit carried by a write strobe |
| flag_o | output | 1 | Current flag value |
| req_n_o | output | 1 | Active-low request, 0 while the flag is set |

## Verification
The embedded assertions check, on every cycle, the cycle-local rules:
- the interval counter never leaves its range;
- an event sets a clear flag;
- the mask wipes all state;
- a write is ignored in interrupt mode;
- a read is ignored in pulse mode;
- no clear happens inside the hold-off window.

The bench scenarios show the rules that need many cycles:
- the exact spacing of events for each interval;
- the half-interval self-clear;
- the deferred clear landing on the 4th tick;
- the fact that an ignored event does not restart the hold-off age.

A behavioural model checked on every clock covers random mixes of mode changes, interval changes and strobes.

// File: rtl/rtc_pflag_pkg.sv
package rtc_pflag_pkg;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_IRQ   = 1'b1
  } flag_mode_e;

  // interval length in ticks for a given select value
  function automatic int unsigned interval_ticks(int unsigned base, int unsigned sel);
    return base << sel;
  endfunction

  // self-restore time: half the interval, never below one tick
  function automatic int unsigned restore_of(int unsigned interval);
    return ((interval >> 1) == 0) ? 1 : (interval >> 1);
  endfunction

endpackage

// File: rtl/rtc_pflag_timer.sv
module rtc_pflag_timer #(
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             mask_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] interval_o,
  output logic             event_o
);
  import rtc_pflag_pkg::*;

  localparam int unsigned MAX_INTERVAL = BASE_TICKS << ((1 << SEL_W) - 1);

  logic [CNT_W-1:0] cnt_q;

  assign interval_o = CNT_W'(interval_ticks(BASE_TICKS, 32'(sel_i)));
  assign event_o    = tick_i && !mask_i && (cnt_q >= interval_o - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (mask_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= event_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_INTERVAL)); // R3

  AST_MASK_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/rtc_pflag_engine.sv
module rtc_pflag_engine #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned HOLD_TICKS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic                       evt_i,
  input  rtc_pflag_pkg::flag_mode_e  mode_i,
  input  logic                       mask_i,
  input  logic                       dprot_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic                       wdata_i,
  input  logic [CNT_W-1:0]           restore_i,
  output logic                       flag_o
);
  import rtc_pflag_pkg::*;

  localparam logic [CNT_W-1:0] AGE_MAX = '1;
  localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_TICKS);

  logic             flag_q, flag_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] age_q, age_d, age_adv;
  logic             hold_done;

  // ticks are aged only while the flag is up; saturate at the top
  assign age_adv   = (tick_i && flag_q && (age_q != AGE_MAX)) ? age_q + CNT_W'(1) : age_q;
  assign hold_done = (age_adv >= HOLD_LIM);

  always_comb begin
    flag_d = flag_q;
    pend_d = pend_q;
    age_d  = age_adv;
    if (mask_i) begin
      flag_d = 1'b0;
      pend_d = 1'b0;
      age_d  = '0;
    end else if (mode_i == MODE_IRQ) begin
      if (!flag_q) begin
        if (evt_i) begin
          flag_d = 1'b1;
          pend_d = 1'b0;
          age_d  = '0;
        end
      end else if ((pend_q && hold_done) || (rd_i && (!dprot_i || hold_done))) begin
        flag_d = 1'b0;
        pend_d = 1'b0;
        age_d  = '0;
      end else if (rd_i) begin
        pend_d = 1'b1;
      end
    end else begin
      pend_d = 1'b0;
      if (evt_i) begin
        flag_d = 1'b1;
        age_d  = '0;
      end else if (flag_q && ((wr_i && !wdata_i) || (age_adv >= restore_i))) begin
        flag_d = 1'b0;
        age_d  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      age_q  <= '0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
      age_q  <= age_d;
    end
  end

  assign flag_o = flag_q;

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !mask_i && !flag_q) |=> flag_q); // R3

  AST_MASK_WIPES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> (!flag_q && !pend_q && (age_q == '0))); // R4

  AST_IRQ_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_IRQ) && !mask_i && flag_q && wr_i && !rd_i && !pend_q) |=> flag_q); // R6

  AST_HOLDOFF_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_IRQ) && dprot_i && flag_q && !mask_i && !tick_i && (age_q < HOLD_LIM)) |=> flag_q); // R8

  AST_PEND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> flag_q); // R8

  AST_PULSE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_PULSE) && flag_q && !mask_i && rd_i && !wr_i && !tick_i) |=> flag_q); // R11

endmodule

// File: rtl/rtc_periodic_flag.sv
module rtc_periodic_flag #(
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned HOLD_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             irq_mode,
  input  logic             mask,
  input  logic             delay_protect,
  input  logic             flag_rd,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             flag_o,
  output logic             req_n_o
);
  import rtc_pflag_pkg::*;

  localparam int unsigned MAX_INTERVAL = BASE_TICKS << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W        = $clog2(MAX_INTERVAL) + 1;

  logic [CNT_W-1:0] interval;
  logic [CNT_W-1:0] restore;
  logic             evt;
  logic             flag;
  flag_mode_e       mode;

  assign mode    = irq_mode ? MODE_IRQ : MODE_PULSE;
  assign restore = CNT_W'(restore_of(32'(interval)));

  rtc_pflag_timer #(
    .BASE_TICKS (BASE_TICKS),
    .SEL_W      (SEL_W),
    .CNT_W      (CNT_W)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en),
    .mask_i     (mask),
    .sel_i      (period_sel),
    .interval_o (interval),
    .event_o    (evt)
  );

  rtc_pflag_engine #(
    .CNT_W      (CNT_W),
    .HOLD_TICKS (HOLD_TICKS)
  ) engine_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_en),
    .evt_i     (evt),
    .mode_i    (mode),
    .mask_i    (mask),
    .dprot_i   (delay_protect),
    .rd_i      (flag_rd),
    .wr_i      (flag_wr),
    .wdata_i   (flag_wdata),
    .restore_i (restore),
    .flag_o    (flag)
  );

  assign flag_o  = flag;
  assign req_n_o = ~flag;

endmodule

// File: tb/rtc_periodic_flag_tb_top.sv
module rtc_periodic_flag_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       mode = 1'b0;
  logic       mask = 1'b0;
  logic       dprot = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic       wdata = 1'b0;
  logic       flag_o;
  logic       req_n;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  rtc_periodic_flag dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .period_sel(sel),
    .irq_mode(mode), .mask(mask), .delay_protect(dprot),
    .flag_rd(rd), .flag_wr(wr), .flag_wdata(wdata),
    .flag_o(flag_o), .req_n_o(req_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_age = 0, m_flag = 0, m_pend = 0;
  always @(posedge clk) begin
    int per, rt, age_a;
    bit evt;
    if (!rst_n) begin
      m_cnt = 0; m_age = 0; m_flag = 0; m_pend = 0;
    end else begin
      per = 4 << sel;
      rt = (per / 2 < 1) ? 1 : per / 2;
      evt = tick && !mask && (m_cnt >= per - 1);
      age_a = (tick && m_flag == 1 && m_age < 1023) ? m_age + 1 : m_age;
      if (mask) begin
        m_cnt = 0; m_age = 0; m_flag = 0; m_pend = 0;
      end else begin
        if (tick) m_cnt = evt ? 0 : m_cnt + 1;
        if (mode) begin
          if (m_flag == 0) begin
            if (evt) begin m_flag = 1; m_age = 0; m_pend = 0; end
          end else if ((m_pend == 1 && age_a >= 4) || (rd && (!dprot || age_a >= 4))) begin
            m_flag = 0; m_age = 0; m_pend = 0;
          end else begin
            m_age = age_a;
            if (rd) m_pend = 1;
          end
        end else begin
          m_pend = 0;
          if (evt) begin m_flag = 1; m_age = 0; end
          else if (m_flag == 1 && ((wr && !wdata) || age_a >= rt)) begin m_flag = 0; m_age = 0; end
          else m_age = age_a;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check(flag_o === m_flag[0], {cur_tag, " model flag"}, int'(flag_o), m_flag);
      check(req_n === !m_flag[0], "R2 request line", int'(req_n), int'(!m_flag[0]));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic do_read();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_write(input bit d);
    wr = 1'b1; wdata = d; @(negedge clk); wr = 1'b0; wdata = 1'b0;
  endtask

  task automatic wipe();
    mask = 1'b1; @(negedge clk); mask = 1'b0;
  endtask

  task automatic rise_ticks(output int n);
    bit prev;
    n = 0;
    forever begin
      prev = flag_o;
      tick_n(1);
      n++;
      if (!prev && flag_o) break;
      if (n > 2000) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(flag_o == 1'b0, "R1 flag after reset", int'(flag_o), 0);
    check(req_n == 1'b1, "R1 request after reset", int'(req_n), 1);
    model_on = 1'b1;

    // R3: interval spacing in pulse mode
    cur_tag = "R3";
    mode = 1'b0; sel = 3'd0;
    wipe();
    rise_ticks(n);
    check(n == 4, "R3 first interval sel0", n, 4);
    rise_ticks(n);
    check(n == 4, "R3 interval sel0", n, 4);
    sel = 3'd1;
    rise_ticks(n);
    rise_ticks(n);
    check(n == 8, "R3 interval sel1", n, 8);

    // R9: self-restore after half interval (sel1 -> 4 ticks)
    cur_tag = "R9";
    tick_n(3);
    check(flag_o == 1'b1, "R9 flag held before restore", int'(flag_o), 1);
    check(req_n == 1'b0, "R2 request low with flag", int'(req_n), 0);
    tick_n(1);
    check(flag_o == 1'b0, "R9 flag restored", int'(flag_o), 0);

    // R11: read has no effect in pulse mode
    cur_tag = "R11";
    rise_ticks(n);
    do_read();
    check(flag_o == 1'b1, "R11 read keeps flag", int'(flag_o), 1);

    // R10: write 1 keeps, write 0 clears
    cur_tag = "R10";
    do_write(1'b1);
    check(flag_o == 1'b1, "R10 write one keeps flag", int'(flag_o), 1);
    do_write(1'b0);
    check(flag_o == 1'b0, "R10 write zero clears flag", int'(flag_o), 0);
    do_write(1'b1);
    check(flag_o == 1'b0, "R10 write one does not set", int'(flag_o), 0);

    // R4: mask clears and blocks
    cur_tag = "R4";
    rise_ticks(n);
    mask = 1'b1; step();
    check(flag_o == 1'b0, "R4 mask clears flag", int'(flag_o), 0);
    tick_n(40);
    check(flag_o == 1'b0, "R4 no event while masked", int'(flag_o), 0);
    mask = 1'b0;
    rise_ticks(n);
    check(n == 8, "R4 counter restarted by mask", n, 8);

    // R5: interrupt mode read clear
    cur_tag = "R5";
    wipe();
    mode = 1'b1; dprot = 1'b0; sel = 3'd1;
    rise_ticks(n);
    tick_n(2);
    check(flag_o == 1'b1, "R5 flag held until read", int'(flag_o), 1);
    do_read();
    check(flag_o == 1'b0, "R5 read clears flag", int'(flag_o), 0);

    // R6: writes ignored in interrupt mode
    cur_tag = "R6";
    rise_ticks(n);
    do_write(1'b0);
    check(flag_o == 1'b1, "R6 write zero ignored", int'(flag_o), 1);
    do_write(1'b1);
    check(flag_o == 1'b1, "R6 write one ignored", int'(flag_o), 1);
    do_read();

    // R7: ignored event does not restart hold-off age
    cur_tag = "R7";
    dprot = 1'b1;
    rise_ticks(n);
    tick_n(8);
    check(flag_o == 1'b1, "R7 flag stays through ignored event", int'(flag_o), 1);
    do_read();
    check(flag_o == 1'b0, "R7 read after ignored event clears at once", int'(flag_o), 0);

    // R8: deferred clear with delay protection
    cur_tag = "R8";
    sel = 3'd2;
    wipe();
    rise_ticks(n);
    do_read();
    check(flag_o == 1'b1, "R8 early read deferred", int'(flag_o), 1);
    tick_n(3);
    check(flag_o == 1'b1, "R8 flag held inside window", int'(flag_o), 1);
    tick_n(1);
    check(flag_o == 1'b0, "R8 deferred clear on 4th tick", int'(flag_o), 0);
    rise_ticks(n);
    tick_n(4);
    check(flag_o == 1'b1, "R8 no clear without read", int'(flag_o), 1);
    do_read();
    check(flag_o == 1'b0, "R8 late read clears at once", int'(flag_o), 0);

    // random mix against the model
    cur_tag = "R2/R3/R5/R8/R9/R10";
    for (int i = 0; i < 6000; i++) begin
      tick  = ($urandom % 2) == 0;
      rd    = ($urandom % 8) == 0;
      wr    = ($urandom % 8) == 0;
      wdata = ($urandom % 2) == 0;
      if (($urandom % 200) == 0) mode = ~mode;
      if (($urandom % 150) == 0) sel = 3'($urandom % 4);
      if (($urandom % 100) == 0) dprot = ~dprot;
      mask = ($urandom % 300) == 0;
      step();
    end
    tick = 1'b0; rd = 1'b0; wr = 1'b0; mask = 1'b0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule